// File: doc/BRIEF.md
# MDIO Management Frame Controller

This block is a bus-attached controller for a clause-22 station management interface. It lets software read and write PHY registers over the MDC clock and the bidirectional MDIO data line. Software first enables management mode and programs an MDC divider. It then writes one complete 32-bit management frame word into the data register. That write starts the transfer. The frame word carries the start code, opcode, PHY address, register address, turnaround and data fields.

The controller first sends a preamble of 32 ones. It then shifts the frame out MSB first, with MDIO changing on MDC falling edges. On a read opcode it releases the line for the PHY and samples 16 data bits on MDC rising edges. The captured value lands in the low half of the data register. Completion raises a write-one-to-clear event flag. A busy status bit covers the whole transaction.

The sequencer moves through four states:
- IDLE goes to PRE on an accepted launch.
- PRE goes to FRAME on the MDC falling edge that ends the last preamble bit.
- FRAME goes to FINISH on the falling edge that ends frame bit 0.
- FINISH goes to IDLE unconditionally one cycle later, writing the result and raising the event.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After reset, every readable register reads zero, MDC is low and MDIO is not driven (output enable low).
- R2: A write to the data register (address 2) while the mode bit (address 0, bit 0) is set and the block is idle is accepted. Busy (address 1, bit 1) reads high from the next cycle. The block then drives MDIO high for 32 MDC cycles of preamble.
- R3: The speed value is stored from write-data bits 6:1 at address 3, and reads back at bits 6:1 with all other bits zero. With speed S nonzero, MDC starts low after launch and toggles every S clocks, giving a period of 2*S clocks.
- R4: After the preamble, the 32 frame-word bits are driven from bit 31 down to bit 0. MDIO changes only together with an MDC falling edge.
- R5: When frame bits 29:28 equal 10 (read), MDIO is driven up to and including frame bit 17. Output enable is low from frame bit 16 onward. The 16 values sampled at the rising MDC edges of frame bits 15..0 are stored MSB first into data-register bits 15:0, and bits 31:16 are kept.
- R6: For any other opcode, all 32 frame bits are driven and the data register is unchanged at completion.
- R7: Busy falls and the event flag (address 1, bit 0) rises in the same cycle, which is 128*S+1 clocks after the launch edge.
- R8: Writing 1 to address 1 bit 0 clears the event flag, and writing 0 there has no effect. If a clear coincides with completion, the flag stays set.
- R9: A data-register write while the mode bit is clear is ignored: busy stays low and the data register is unchanged.
- R10: A data-register write while busy is ignored: the running frame and the data register are unaffected.
- R11: With speed 0, MDC stays stopped and a launched transaction holds in place. It resumes from the same point once a nonzero speed is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register write address |
| bus_wdata | input | 32 | Register write data |
| bus_raddr | input | 2 | Register read address |
| bus_rdata | output | 32 | Register read data (combinational) |
| mdc | output | 1 | Management clock |
| mdio_i | input | 1 | MDIO input from the pad |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |

## Verification
The bound checker watches several rules on every cycle:
- The line is quiet while idle.
- Preamble is driven high.
- MDIO moves only with a falling MDC.
- Completion sets the event and ends busy.
- A disabled mode never starts a frame.
- The frame word stays frozen while busy.
- MDC stays still at speed 0.

Only the bench scenarios can show the rest. That covers exact MDC timing against the speed value, the read release point, and MSB-first capture of PHY data into the register. It also covers write-one-to-clear semantics including the coincident clear, and resumption after a stalled divider.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PRE,
        ST_FRAME,
        ST_FINISH
    } mdio_st_t;

    localparam int REG_AW   = 2;
    localparam logic [REG_AW-1:0] A_MODE  = 2'd0;
    localparam logic [REG_AW-1:0] A_EVENT = 2'd1;
    localparam logic [REG_AW-1:0] A_DATA  = 2'd2;
    localparam logic [REG_AW-1:0] A_SPEED = 2'd3;

    localparam int EV_DONE_BIT = 0;
    localparam int EV_BUSY_BIT = 1;
    localparam int SPD_LSB     = 1;

    localparam logic [1:0] OP_READ = 2'b10;

endpackage

// File: rtl/mdio_clkdiv.sv
module mdio_clkdiv #(
    parameter int SPD_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [SPD_W-1:0] speed,
    output logic             mdc,
    output logic             rise_stb,
    output logic             fall_stb
);

    logic [SPD_W-1:0] cnt;
    logic             edge_hit;

    assign edge_hit = run && (speed != '0) && (cnt >= speed - SPD_W'(1));
    assign rise_stb = edge_hit && !mdc;
    assign fall_stb = edge_hit && mdc;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (speed != '0) begin
            if (edge_hit) begin
                cnt <= '0;
                mdc <= ~mdc;
            end else begin
                cnt <= cnt + SPD_W'(1);
            end
        end
    end

endmodule

// File: rtl/mdio_engine.sv
module mdio_engine
    import mdio_pkg::*;
#(
    parameter int PRE_LEN = 32,
    parameter int FRAME_W = 32,
    parameter int DATA_W  = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [FRAME_W-1:0] word,
    input  logic               rise_stb,
    input  logic               fall_stb,
    input  logic               mdio_i,
    output logic               run,
    output logic               busy,
    output logic               in_pre,
    output logic               done_stb,
    output logic               rd_op,
    output logic [DATA_W-1:0]  cap,
    output logic               mdio_o,
    output logic               mdio_oe
);

    localparam int LEN_MAX    = (PRE_LEN > FRAME_W) ? PRE_LEN : FRAME_W;
    localparam int CW         = $clog2(LEN_MAX);
    localparam int SAMPLE_IDX = FRAME_W - DATA_W;
    localparam int REL_IDX    = SAMPLE_IDX - 1;

    mdio_st_t      state, next;
    logic [CW-1:0] cnt;
    logic          pre_last, frame_last;

    assign rd_op      = (word[FRAME_W-3 -: 2] == OP_READ);
    assign pre_last   = (cnt == CW'(PRE_LEN - 1));
    assign frame_last = (cnt == CW'(FRAME_W - 1));

    always_comb begin
        next = state;
        unique case (state)
            ST_IDLE:   if (start) next = ST_PRE;
            ST_PRE:    if (fall_stb && pre_last) next = ST_FRAME;
            ST_FRAME:  if (fall_stb && frame_last) next = ST_FINISH;
            ST_FINISH: next = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt   <= '0;
            cap   <= '0;
        end else begin
            state <= next;
            if (state != next) begin
                cnt <= '0;
            end else if (fall_stb) begin
                cnt <= cnt + CW'(1);
            end
            if (start && state == ST_IDLE) begin
                cap <= '0;
            end else if (state == ST_FRAME && rise_stb && rd_op &&
                         cnt >= CW'(SAMPLE_IDX)) begin
                cap <= {cap[DATA_W-2:0], mdio_i};
            end
        end
    end

    always_comb begin
        mdio_o   = 1'b0;
        mdio_oe  = 1'b0;
        run      = 1'b0;
        busy     = 1'b1;
        in_pre   = 1'b0;
        done_stb = 1'b0;
        unique case (state)
            ST_IDLE: begin
                busy = 1'b0;
            end
            ST_PRE: begin
                run     = 1'b1;
                in_pre  = 1'b1;
                mdio_o  = 1'b1;
                mdio_oe = 1'b1;
            end
            ST_FRAME: begin
                run     = 1'b1;
                mdio_o  = word[CW'(FRAME_W - 1) - cnt];
                mdio_oe = !(rd_op && cnt >= CW'(REL_IDX));
            end
            ST_FINISH: begin
                done_stb = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/mdio_regs.sv
module mdio_regs
    import mdio_pkg::*;
#(
    parameter int SPD_W   = 6,
    parameter int FRAME_W = 32,
    parameter int DATA_W  = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_we,
    input  logic [REG_AW-1:0]  bus_addr,
    input  logic [FRAME_W-1:0] bus_wdata,
    input  logic [REG_AW-1:0]  bus_raddr,
    output logic [FRAME_W-1:0] bus_rdata,
    input  logic               busy,
    input  logic               done_stb,
    input  logic               rd_op,
    input  logic [DATA_W-1:0]  cap,
    output logic               mode_en,
    output logic [SPD_W-1:0]   speed,
    output logic               start,
    output logic [FRAME_W-1:0] word,
    output logic               event_flag
);

    assign start = bus_we && bus_addr == A_DATA && mode_en && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_en    <= 1'b0;
            speed      <= '0;
            word       <= '0;
            event_flag <= 1'b0;
        end else begin
            if (bus_we && bus_addr == A_MODE)  mode_en <= bus_wdata[0];
            if (bus_we && bus_addr == A_SPEED) speed   <= bus_wdata[SPD_LSB +: SPD_W];
            if (start) begin
                word <= bus_wdata;
            end else if (done_stb && rd_op) begin
                word[DATA_W-1:0] <= cap;
            end
            if (done_stb) begin
                event_flag <= 1'b1;
            end else if (bus_we && bus_addr == A_EVENT && bus_wdata[EV_DONE_BIT]) begin
                event_flag <= 1'b0;
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_raddr)
            A_MODE:  bus_rdata[0] = mode_en;
            A_EVENT: begin
                bus_rdata[EV_DONE_BIT] = event_flag;
                bus_rdata[EV_BUSY_BIT] = busy;
            end
            A_DATA:  bus_rdata = word;
            A_SPEED: bus_rdata[SPD_LSB +: SPD_W] = speed;
        endcase
    end

endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
    import mdio_pkg::*;
#(
    parameter int SPD_W   = 6,
    parameter int PRE_LEN = 32,
    parameter int FRAME_W = 32,
    parameter int DATA_W  = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_we,
    input  logic [1:0]         bus_addr,
    input  logic [31:0]        bus_wdata,
    input  logic [1:0]         bus_raddr,
    output logic [31:0]        bus_rdata,
    output logic               mdc,
    input  logic               mdio_i,
    output logic               mdio_o,
    output logic               mdio_oe
);

    logic              run, busy, in_pre, done_stb, rd_op, start;
    logic              rise_stb, fall_stb, mode_en, event_flag;
    logic [SPD_W-1:0]  speed;
    logic [DATA_W-1:0] cap;
    logic [31:0]       word;

    mdio_regs #(.SPD_W(SPD_W), .FRAME_W(FRAME_W), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst(rst),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_raddr(bus_raddr), .bus_rdata(bus_rdata),
        .busy(busy), .done_stb(done_stb), .rd_op(rd_op), .cap(cap),
        .mode_en(mode_en), .speed(speed), .start(start), .word(word),
        .event_flag(event_flag)
    );

    mdio_clkdiv #(.SPD_W(SPD_W)) u_div (
        .clk(clk), .rst(rst), .run(run), .speed(speed),
        .mdc(mdc), .rise_stb(rise_stb), .fall_stb(fall_stb)
    );

    mdio_engine #(.PRE_LEN(PRE_LEN), .FRAME_W(FRAME_W), .DATA_W(DATA_W)) u_eng (
        .clk(clk), .rst(rst), .start(start), .word(word),
        .rise_stb(rise_stb), .fall_stb(fall_stb), .mdio_i(mdio_i),
        .run(run), .busy(busy), .in_pre(in_pre), .done_stb(done_stb),
        .rd_op(rd_op), .cap(cap), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
    );

endmodule

// File: rtl/mdio_mgmt_chk.sv
module mdio_mgmt_chk #(
    parameter int SPD_W = 6
) (
    input logic             clk,
    input logic             rst,
    input logic             busy,
    input logic             run,
    input logic             in_pre,
    input logic             done_stb,
    input logic             mode_en,
    input logic             event_flag,
    input logic [SPD_W-1:0] speed,
    input logic [31:0]      word,
    input logic             mdc,
    input logic             mdio_o,
    input logic             mdio_oe
);

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mdc && !mdio_oe); // R1

    AST_PRE_DRIVES_ONE: assert property (@(posedge clk) disable iff (rst)
        in_pre |-> mdio_oe && mdio_o); // R2

    AST_MDIO_ON_FALL: assert property (@(posedge clk) disable iff (rst)
        (!$stable(mdio_o) && mdio_oe && $past(mdio_oe)) |-> $fell(mdc)); // R4

    AST_DONE_SETS_EVENT: assert property (@(posedge clk) disable iff (rst)
        done_stb |=> event_flag && !busy); // R7

    AST_DISABLED_NO_START: assert property (@(posedge clk) disable iff (rst)
        (!busy && !mode_en) |=> !busy); // R9

    AST_BUSY_HOLDS_WORD: assert property (@(posedge clk) disable iff (rst)
        (busy && !done_stb) |=> $stable(word)); // R10

    AST_STOPPED_MDC: assert property (@(posedge clk) disable iff (rst)
        (run && speed == '0) |=> $stable(mdc)); // R11

endmodule

bind mdio_mgmt_ctrl mdio_mgmt_chk #(.SPD_W(SPD_W)) u_chk (
    .clk(clk), .rst(rst), .busy(busy), .run(run), .in_pre(in_pre),
    .done_stb(done_stb), .mode_en(mode_en), .event_flag(event_flag),
    .speed(speed), .word(word), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
);

// File: tb/mdio_mgmt_ctrl_test.sv
`timescale 1ns/1ps
module mdio_mgmt_ctrl_test;

    localparam int CLK_PERIOD = 10;
    localparam int PRE = 32;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_we = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [1:0]  bus_raddr = '0;
    logic [31:0] bus_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    // behavioural reference state
    bit          m_busy, m_mode, m_ev, m_rd;
    int          m_S, m_t;
    logic [31:0] m_data;
    logic [15:0] m_cap;
    logic [15:0] phy_val = 16'h0000;

    always #(CLK_PERIOD/2) clk = ~clk;

    mdio_mgmt_ctrl uut (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_raddr(bus_raddr), .bus_rdata(bus_rdata),
        .mdc(mdc), .mdio_i(mdio_i), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        total++;
        if (act !== exp) begin
            bad++;
            if (bad < 30)
                $display("FAIL %s at %0t: actual=%h expected=%h", tag, $time, act, exp);
        end
    endtask

    function automatic int end_t();
        return 2 * m_S * (PRE + 32);
    endfunction

    function automatic logic phy_bit(input int b);
        return phy_val[63 - b];
    endfunction

    // model update at the active edge, from stable inputs and own state only
    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            m_busy = 0; m_mode = 0; m_ev = 0; m_rd = 0;
            m_S = 0; m_t = 0; m_data = '0; m_cap = '0;
        end else begin
            automatic bit was_busy = m_busy;
            automatic bit set_ev = 0;
            if (m_busy) begin
                if (m_S != 0 && m_t == end_t()) begin
                    m_busy = 0;
                    set_ev = 1;
                    if (m_rd) m_data[15:0] = m_cap;
                end else if (m_S != 0) begin
                    if (m_t % (2 * m_S) == m_S - 1 && m_t / (2 * m_S) >= 48)
                        m_cap = {m_cap[14:0], phy_bit(m_t / (2 * m_S))};
                    m_t++;
                end
            end
            if (bus_we) begin
                case (bus_addr)
                    2'd0: m_mode = bus_wdata[0];
                    2'd1: if (bus_wdata[0]) m_ev = 0;
                    2'd2: if (m_mode && !was_busy) begin
                        m_data = bus_wdata;
                        m_rd = (bus_wdata[29:28] == 2'b10);
                        m_busy = 1; m_t = 0; m_cap = '0;
                    end
                    default: m_S = int'(bus_wdata[6:1]);
                endcase
            end
            if (set_ev) m_ev = 1;
        end
    end

    // compare every cycle away from the edge, then drive the PHY reply
    always @(negedge clk) begin
        if (!rst) begin
            automatic logic e_mdc = 0, e_oe = 0, e_o = 0;
            automatic logic [31:0] e_rd = '0;
            automatic int b = -1;
            if (m_busy && !(m_S != 0 && m_t == end_t())) begin
                b = (m_S == 0) ? 0 : m_t / (2 * m_S);
                e_mdc = (m_S == 0) ? 1'b0 : logic'((m_t / m_S) % 2);
                if (b < PRE) begin
                    e_oe = 1; e_o = 1;
                end else begin
                    e_oe = !(m_rd && (b - PRE) >= 15);
                    e_o = m_data[31 - (b - PRE)];
                end
            end
            case (bus_raddr)
                2'd0: e_rd = {31'b0, m_mode};
                2'd1: e_rd = {30'b0, m_busy, m_ev};
                2'd2: e_rd = m_data;
                default: e_rd = {25'b0, 6'(m_S), 1'b0};
            endcase
            chk({31'b0, mdc}, {31'b0, e_mdc}, "R3 mdc");
            chk({31'b0, mdio_oe}, {31'b0, e_oe}, "R5 mdio_oe");
            if (e_oe) chk({31'b0, mdio_o}, {31'b0, e_o}, "R4 mdio_o");
            chk(bus_rdata, e_rd, "R7 rdata");
            mdio_i <= (m_rd && b >= 48) ? phy_bit(b) : 1'b1;
        end
    end

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        bus_we = 1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_we = 0;
    endtask

    task automatic rd_chk(input logic [1:0] a, input logic [31:0] e, input string tag);
        @(posedge clk); #1;
        bus_raddr = a;
        @(negedge clk);
        chk(bus_rdata, e, tag);
    endtask

    task automatic wait_idle();
        int n = 0;
        while (m_busy && n < 20000) begin
            @(posedge clk); #1;
            n++;
        end
    endtask

    task automatic wait_t(input int tt);
        int n = 0;
        while (!(m_busy && m_t == tt) && n < 20000) begin
            @(negedge clk);
            n++;
        end
    endtask

    initial begin
        int launch_cyc;
        repeat (3) @(posedge clk);
        #1 rst = 0;

        // R1: reset state
        rd_chk(2'd0, 32'h0, "R1 mode");
        rd_chk(2'd1, 32'h0, "R1 event");
        rd_chk(2'd2, 32'h0, "R1 data");
        rd_chk(2'd3, 32'h0, "R1 speed");
        chk({31'b0, mdc}, 32'h0, "R1 mdc");
        chk({31'b0, mdio_oe}, 32'h0, "R1 mdio_oe");

        // R9: disabled mode ignores launch
        wr(2'd3, 32'h4);
        wr(2'd2, 32'h5002_1234);
        rd_chk(2'd1, 32'h0, "R9 busy");
        rd_chk(2'd2, 32'h0, "R9 data");

        // R3: speed field masking
        wr(2'd3, 32'hFFFF_FF85);
        rd_chk(2'd3, 32'h0000_0004, "R3 speed");

        // R2/R4/R6/R7: write transaction, S=2
        wr(2'd0, 32'h1);
        wr(2'd2, 32'h5002_0000 | (32'd3 << 23) | (32'd4 << 18) | 32'hBEEF);
        launch_cyc = cycles;
        rd_chk(2'd1, 32'h2, "R2 busy");
        chk({31'b0, mdio_oe & mdio_o}, 32'h1, "R2 preamble");
        wait_t(2 * 2 * PRE + 1);
        chk({31'b0, mdio_o}, 32'h0, "R4 start bit0");
        wait_t(2 * 2 * (PRE + 1) + 1);
        chk({31'b0, mdio_o}, 32'h1, "R4 start bit1");
        wait_idle();
        chk(32'(cycles - launch_cyc), 32'(128 * 2 + 1), "R7 latency");
        rd_chk(2'd1, 32'h1, "R7 event");
        rd_chk(2'd2, 32'h5002_0000 | (32'd3 << 23) | (32'd4 << 18) | 32'hBEEF, "R6 data");

        // R8: write-one-to-clear
        wr(2'd1, 32'h0);
        rd_chk(2'd1, 32'h1, "R8 zero no effect");
        wr(2'd1, 32'h1);
        rd_chk(2'd1, 32'h0, "R8 cleared");

        // R5/R10: read transaction, S=3
        wr(2'd3, 32'h6);
        phy_val = 16'hA5C3;
        wr(2'd2, 32'h6002_0000 | (32'd7 << 23) | (32'd2 << 18));
        wr(2'd2, 32'h5002_FFFF);
        wait_t(2 * 3 * (PRE + 14) + 1);
        chk({31'b0, mdio_oe}, 32'h1, "R5 drive bit17");
        wait_t(2 * 3 * (PRE + 15) + 1);
        chk({31'b0, mdio_oe}, 32'h0, "R5 release bit16");
        wait_idle();
        rd_chk(2'd2, 32'h6002_0000 | (32'd7 << 23) | (32'd2 << 18) | 32'hA5C3, "R5 R10 data");
        wr(2'd1, 32'h1);

        // R11: stalled divider holds, then resumes
        wr(2'd3, 32'h0);
        wr(2'd2, 32'h6002_0000);
        phy_val = 16'h3C5A;
        repeat (20) @(posedge clk);
        @(negedge clk);
        chk({31'b0, mdc}, 32'h0, "R11 mdc stopped");
        rd_chk(2'd1, 32'h2, "R11 still busy");
        wr(2'd3, 32'h2);
        wait_idle();
        rd_chk(2'd2, 32'h6002_3C5A, "R11 resumed");

        // R8: clear coinciding with completion keeps the flag
        wr(2'd1, 32'h1);
        wr(2'd2, 32'h5000_0000);
        while (!(m_busy && m_t == end_t())) begin
            @(posedge clk); #1;
        end
        bus_we = 1; bus_addr = 2'd1; bus_wdata = 32'h1;
        @(posedge clk); #1;
        bus_we = 0;
        rd_chk(2'd1, 32'h1, "R8 set wins");

        repeat (4) @(posedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule